// File: doc/BRIEF.md
# Indirect PHY Register Handshake Master

This block gives a host a plain request port for reaching a PHY register space that has no memory mapping. The PHY sees a 20-bit control word and answers with a 17-bit status word. Only one status bit carries the handshake: an acknowledge. A host request carries an address, write data, a read/write select and a start pulse. The block then steps through a fixed series of strobe phases. Each phase raises one strobe, waits for the acknowledge to rise, drops the strobe and waits for the acknowledge to fall.

The acknowledge is sampled on a slow polling grid, and only a limited number of samples are allowed per wait. If a wait runs out, the access stops at once with an error and the control word returns to zero. A read returns the low 16 bits of the status word, taken at the poll that saw the read acknowledge. That value stays on the read data port until a later read replaces it.

Top module: `phy_hs_master`

## Requirements
- R1: The control word carries a 16-bit field in bits 15:0 and four strobes: capture-address at bit 16, capture-data at bit 17, write at bit 18 and read at bit 19. No more than one strobe is high at any time.
- R2: Every access begins with an address phase. The address alone is driven for one cycle. Then capture-address is raised with the address held until the acknowledge is seen high. Then the address alone is driven until the acknowledge is seen low.
- R3: After the address phase, a write drives the data alone for one cycle. It then drives capture-data with the data until the acknowledge is seen high, and the data alone until it is seen low. Next it drives the write strobe with a zero field until the acknowledge is seen high, then the data alone until it is seen low. Finally it ends with the control word at zero and done high.
- R4: After the address phase, a read drives the read strobe with a zero field until the acknowledge is seen high. At that poll it captures status bits 15:0 as read data. It then drives a zero control word until the acknowledge is seen low, then signals done.
- R5: The acknowledge (status bit 16) is sampled once every POLL_INTERVAL cycles of a wait. The first sample comes POLL_INTERVAL cycles after the wait begins. With an acknowledge that follows the strobes one cycle later, a write completes 3+6*POLL_INTERVAL clock edges after start and a read completes 2+4*POLL_INTERVAL edges after start, counting the edge that samples start as the first.
- R6: A wait that samples the wrong acknowledge level POLL_LIMIT times in a row ends the access. The block then raises done and error together with a zero control word.
- R7: A start while busy is ignored. It does not change the running access, and it does not start another one.
- R8: done is high for exactly one cycle per access. error is high only together with done. busy is high from the cycle after an accepted start until done.
- R9: Read data keeps its value through idle time, write accesses and accesses that time out. Only a completed read acknowledge phase replaces it.
- R10: While reset is asserted, the control word, busy, done, error and read data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_start | input | 1 | Start an access; taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout flag, valid with done |
| rdata | output | 16 | Data from the last completed read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY (bit 16 acknowledge) |

## Verification
The bench uses the default POLL_INTERVAL of 4 and POLL_LIMIT of 10. This keeps a full ten-sample timeout to a few dozen cycles, so both a stuck-low and a stuck-high acknowledge can be run to their exact finishing edge. Because a one-cycle responder delay always lands inside the first sample, the completion edge of every write and read is fixed and can be predicted. Random responder delays of up to three polling periods then exercise the retry path without reaching the limit.

// File: rtl/phy_hs_pkg.sv
`timescale 1ns/1ps
package phy_hs_pkg;
  localparam int unsigned FIELD_W      = 16;
  localparam int unsigned BIT_CAP_ADDR = 16;
  localparam int unsigned BIT_CAP_DATA = 17;
  localparam int unsigned BIT_WRITE    = 18;
  localparam int unsigned BIT_READ     = 19;
  localparam int unsigned CTRL_W       = BIT_READ + 1;
  localparam int unsigned ACK_BIT      = 16;
  localparam int unsigned STAT_W       = ACK_BIT + 1;

  // packed so that cap_addr lands on the lowest strobe bit
  typedef struct packed {
    logic rd;
    logic wr;
    logic cap_data;
    logic cap_addr;
  } strobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ASET, ST_AHI, ST_ALO,
    ST_DSET, ST_DHI, ST_DLO, ST_WHI, ST_WLO,
    ST_RHI, ST_RLO
  } hs_state_e;
endpackage

// File: rtl/phy_hs_rst_sync.sv
`timescale 1ns/1ps
module phy_hs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/phy_hs_poll.sv
`timescale 1ns/1ps
module phy_hs_poll #(
  parameter int unsigned INTERVAL = 4,
  parameter int unsigned LIMIT    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic want,
  input  logic ack,
  output logic hit,
  output logic expire
);
  localparam int unsigned TW = $clog2(INTERVAL + 1);
  localparam int unsigned AW = $clog2(LIMIT + 1);

  logic [TW-1:0] tmr_q, tmr_n;
  logic [AW-1:0] att_q, att_n;
  logic          poll_now, matched;

  assign poll_now = run && (tmr_q == TW'(INTERVAL - 1));
  assign matched  = (ack == want);
  assign hit      = poll_now && matched;
  assign expire   = poll_now && !matched && (att_q == AW'(LIMIT - 1));

  always_comb begin
    tmr_n = tmr_q;
    att_n = att_q;
    if (!run || restart) begin
      tmr_n = '0;
      att_n = '0;
    end else if (poll_now) begin
      tmr_n = '0;
      att_n = att_q + AW'(1);
    end else begin
      tmr_n = tmr_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      att_q <= '0;
    end else begin
      tmr_q <= tmr_n;
      att_q <= att_n;
    end
  end

  // R6: failed samples never pile up beyond the limit
  assert_attempt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    att_q < AW'(LIMIT));
  // R5: between samples the timer runs without a poll
  assert_poll_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || expire) |=> !(hit || expire));
endmodule

// File: rtl/phy_hs_seq.sv
`timescale 1ns/1ps
module phy_hs_seq
  import phy_hs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               write,
  input  logic [FIELD_W-1:0] addr,
  input  logic [FIELD_W-1:0] wdata,
  input  logic [FIELD_W-1:0] stat_data,
  input  logic               hit,
  input  logic               expire,
  output logic               run,
  output logic               want,
  output logic               restart,
  output strobe_t            strb,
  output logic [FIELD_W-1:0] field,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic [FIELD_W-1:0] rdata
);
  hs_state_e          state_q, state_n;
  logic [FIELD_W-1:0] addr_q, data_q, rdata_q;
  logic               wr_q, done_q, err_q;
  logic               accept, finish, rd_sample;

  assign accept    = (state_q == ST_IDLE) && start;
  assign rd_sample = (state_q == ST_RHI) && hit;

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE: if (start) state_n = ST_ASET;
      ST_ASET: state_n = ST_AHI;
      ST_AHI:  if (hit) state_n = ST_ALO;
      ST_ALO:  if (hit) state_n = wr_q ? ST_DSET : ST_RHI;
      ST_DSET: state_n = ST_DHI;
      ST_DHI:  if (hit) state_n = ST_DLO;
      ST_DLO:  if (hit) state_n = ST_WHI;
      ST_WHI:  if (hit) state_n = ST_WLO;
      ST_WLO:  if (hit) state_n = ST_IDLE;
      ST_RHI:  if (hit) state_n = ST_RLO;
      ST_RLO:  if (hit) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
    if (expire) state_n = ST_IDLE;
  end

  assign finish  = (state_q != ST_IDLE) && (state_n == ST_IDLE);
  assign restart = (state_n != state_q);

  always_comb begin
    run = 1'b0;
    want = 1'b0;
    case (state_q)
      ST_AHI, ST_DHI, ST_WHI, ST_RHI: begin run = 1'b1; want = 1'b1; end
      ST_ALO, ST_DLO, ST_WLO, ST_RLO: run = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    strb  = '0;
    field = '0;
    case (state_q)
      ST_ASET, ST_ALO: field = addr_q;
      ST_AHI:  begin field = addr_q; strb.cap_addr = 1'b1; end
      ST_DSET, ST_DLO, ST_WLO: field = data_q;
      ST_DHI:  begin field = data_q; strb.cap_data = 1'b1; end
      ST_WHI:  strb.wr = 1'b1;
      ST_RHI:  strb.rd = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= finish;
      err_q   <= expire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      addr_q <= addr;
      data_q <= wdata;
      wr_q   <= write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_sample) rdata_q <= stat_data;
  end

  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;
  assign error = err_q;
  assign rdata = rdata_q;

  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
  assert_read_field_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rd || strb.wr) |-> (field == '0));
  assert_end_ctrl_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (strb == '0 && field == '0));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_error_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q);
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(addr_q) && $stable(data_q) && $stable(wr_q)));
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RHI) |=> $stable(rdata_q));
endmodule

// File: rtl/phy_hs_master.sv
`timescale 1ns/1ps
module phy_hs_master
  import phy_hs_pkg::*;
#(
  parameter int unsigned POLL_INTERVAL = 4,
  parameter int unsigned POLL_LIMIT    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_start,
  input  logic               req_write,
  input  logic [FIELD_W-1:0] req_addr,
  input  logic [FIELD_W-1:0] req_wdata,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic [FIELD_W-1:0] rdata,
  output logic [CTRL_W-1:0]  phy_ctrl,
  input  logic [STAT_W-1:0]  phy_stat
);
  logic               core_rst_n;
  logic               run, want, restart, hit, expire;
  strobe_t            strb;
  logic [FIELD_W-1:0] field;

  phy_hs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(core_rst_n)
  );

  phy_hs_poll #(.INTERVAL(POLL_INTERVAL), .LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(core_rst_n), .run(run), .restart(restart),
    .want(want), .ack(phy_stat[ACK_BIT]), .hit(hit), .expire(expire)
  );

  phy_hs_seq u_seq (
    .clk(clk), .rst_n(core_rst_n), .start(req_start), .write(req_write),
    .addr(req_addr), .wdata(req_wdata), .stat_data(phy_stat[FIELD_W-1:0]),
    .hit(hit), .expire(expire), .run(run), .want(want), .restart(restart),
    .strb(strb), .field(field), .busy(busy), .done(done), .error(error),
    .rdata(rdata)
  );

  assign phy_ctrl = {strb, field};
endmodule

// File: tb/test_phy_hs_master.sv
`timescale 1ns/1ps
module test_phy_hs_master;
  localparam int PI = 4;
  localparam int PL = 10;

  logic        clk, rst_n;
  logic        req_start, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        busy, done, error;
  logic [15:0] rdata;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  int n_chk = 0;
  int n_fail = 0;

  phy_hs_master #(.POLL_INTERVAL(PI), .POLL_LIMIT(PL)) i_phy_hs_master (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .error(error), .rdata(rdata), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] init_val(input int i);
    return 16'(i * 16'h0101) ^ 16'h5A5A;
  endfunction
  function automatic int lat_write(); return 3 + 6 * PI; endfunction
  function automatic int lat_read();  return 2 + 4 * PI; endfunction

  // ---------------- PHY responder model ----------------
  int          dly;   // edges for ack to follow strobes
  int          mode;  // 0 normal, 1 ack stuck low, 2 ack never falls
  logic        ack_m;
  int          acnt;
  logic [15:0] mem [256];
  logic [15:0] la, ld;
  logic [19:0] prev;
  int rise_ca, rise_cd, rise_wr, rise_rd, viol;
  logic tgt;

  always_comb begin
    if (mode == 1)                tgt = 1'b0;
    else if (mode == 2 && ack_m)  tgt = 1'b1;
    else                          tgt = |phy_ctrl[19:16];
  end

  assign phy_stat = {ack_m, phy_ctrl[19] ? mem[la[7:0]] : ~mem[la[7:0]]};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= 1'b0; acnt <= 0; prev <= '0; la <= '0; ld <= '0;
      rise_ca <= 0; rise_cd <= 0; rise_wr <= 0; rise_rd <= 0; viol <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else begin
      prev <= phy_ctrl;
      if (tgt != ack_m) begin
        if (acnt + 1 >= dly) begin ack_m <= tgt; acnt <= 0; end
        else acnt <= acnt + 1;
      end else acnt <= 0;
      if (phy_ctrl[16]) la <= phy_ctrl[15:0];
      if (phy_ctrl[17]) ld <= phy_ctrl[15:0];
      if (phy_ctrl[16] && !prev[16]) rise_ca <= rise_ca + 1;
      if (phy_ctrl[17] && !prev[17]) rise_cd <= rise_cd + 1;
      if (phy_ctrl[18] && !prev[18]) begin
        rise_wr <= rise_wr + 1;
        mem[la[7:0]] <= ld;
      end
      if (phy_ctrl[19] && !prev[19]) rise_rd <= rise_rd + 1;
      if (!$onehot0(phy_ctrl[19:16]) ||
          ((phy_ctrl[18] || phy_ctrl[19]) && phy_ctrl[15:0] != 16'h0) ||
          (((phy_ctrl[16] && !prev[16]) || (phy_ctrl[17] && !prev[17])) &&
           (prev[19:16] != 4'h0 || prev[15:0] != phy_ctrl[15:0])) ||
          (phy_ctrl[16] && prev[16] && prev[15:0] != phy_ctrl[15:0]))
        viol <= viol + 1;
    end
  end

  // ---------------- bench helpers ----------------
  logic [15:0] shadow [256];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic run_access(input bit w, input logic [15:0] a, input logic [15:0] d,
                            input int stray_at, output int n, output bit er,
                            output bit busy_ok, output logic [19:0] ctrl_end);
    bit fin;
    n = 0; busy_ok = 1'b1; fin = 1'b0;
    req_start = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!fin) begin
      @(posedge clk); n++; @(negedge clk);
      if (n == 1) req_start = 1'b0;
      if (stray_at != 0 && n == stray_at) begin
        req_start = 1'b1; req_write = 1'b1; req_addr = a ^ 16'h0055; req_wdata = 16'hBEEF;
      end else if (stray_at != 0 && n == stray_at + 1) req_start = 1'b0;
      if (done) fin = 1'b1;
      else if (!busy) busy_ok = 1'b0;
      if (n > 400) fin = 1'b1;
    end
    er = error;
    ctrl_end = phy_ctrl;
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", 32'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual=hung expected=completion");
    summary();
    $finish;
  end

  initial begin
    int n; bit er, bok; logic [19:0] ce;
    int c_ca, c_cd, c_wr, c_rd;
    logic [15:0] keep;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
    rst_n = 1'b0; req_start = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    dly = 1; mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phy_ctrl == 0 && !busy && !done && !error && rdata == 0, "R10 reset state",
        {busy, done, error, 13'b0, rdata}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed write, timing and strobe counts
    c_ca = rise_ca; c_cd = rise_cd; c_wr = rise_wr; c_rd = rise_rd;
    run_access(1'b1, 16'h1234, 16'hA5C3, 0, n, er, bok, ce);
    shadow[8'h34] = 16'hA5C3;
    chk(n == lat_write(), "R5 R3 write latency", n, lat_write());
    chk(!er && bok && ce == 0, "R3 write ends clean", {er, bok, 10'b0, ce}, 32'h0400000 >> 10);
    chk(rise_ca - c_ca == 1 && rise_cd - c_cd == 1 && rise_wr - c_wr == 1 && rise_rd == c_rd,
        "R3 write strobe sequence", rise_wr - c_wr, 1);

    // directed read back
    c_ca = rise_ca; c_rd = rise_rd; c_cd = rise_cd;
    run_access(1'b0, 16'h1234, 16'h0, 0, n, er, bok, ce);
    chk(n == lat_read(), "R5 R4 read latency", n, lat_read());
    chk(rdata == 16'hA5C3 && !er, "R4 read data", rdata, 16'hA5C3);
    chk(rise_ca - c_ca == 1 && rise_rd - c_rd == 1 && rise_cd == c_cd,
        "R2 read strobe sequence", rise_rd - c_rd, 1);

    run_access(1'b0, 16'h0077, 16'h0, 0, n, er, bok, ce);
    chk(rdata == init_val(8'h77), "R4 read untouched reg", rdata, init_val(8'h77));

    // start while busy
    run_access(1'b0, 16'h0012, 16'h0, 5, n, er, bok, ce);
    chk(n == lat_read() && rdata == init_val(8'h12), "R7 stray start during read",
        n, lat_read());
    run_access(1'b0, 16'h0012 ^ 16'h0055, 16'h0, 0, n, er, bok, ce);
    chk(rdata == init_val(8'h47), "R7 stray write not performed", rdata, init_val(8'h47));

    // rdata hold
    keep = rdata;
    repeat (20) @(negedge clk);
    chk(rdata == keep, "R9 rdata held while idle", rdata, keep);
    run_access(1'b1, 16'h0003, 16'h0F0F, 0, n, er, bok, ce);
    shadow[3] = 16'h0F0F;
    chk(rdata == keep, "R9 rdata held over write", rdata, keep);

    // timeout, acknowledge never rises
    mode = 1;
    run_access(1'b1, 16'h0009, 16'h7777, 0, n, er, bok, ce);
    chk(n == 2 + PL * PI, "R6 stuck-low timeout latency", n, 2 + PL * PI);
    chk(er && ce == 0, "R6 stuck-low error and idle ctrl", {er, 11'b0, ce}, 32'h100000);
    mode = 0;
    repeat (4) @(negedge clk);

    // timeout, acknowledge never falls
    mode = 2;
    run_access(1'b0, 16'h0003, 16'h0, 0, n, er, bok, ce);
    chk(n == 2 + PI + PL * PI, "R6 stuck-high timeout latency", n, 2 + PI + PL * PI);
    chk(er && ce == 0, "R6 stuck-high error and idle ctrl", {er, 11'b0, ce}, 32'h100000);
    chk(rdata == keep, "R9 rdata held over timeout", rdata, keep);
    mode = 0;
    repeat (6) @(negedge clk);

    run_access(1'b0, 16'h0009, 16'h0, 0, n, er, bok, ce);
    chk(rdata == init_val(9) && !er, "R6 timed-out write left no trace", rdata, init_val(9));

    // random traffic
    for (int k = 0; k < 80; k++) begin
      bit w; logic [15:0] a, d;
      w = 1'($urandom % 2);
      a = 16'($urandom);
      d = 16'($urandom);
      dly = 1 + int'($urandom % 12);
      run_access(w, a, d, 0, n, er, bok, ce);
      chk(!er && bok && ce == 0, "R8 random access status", {er, bok, 10'b0, ce}, 32'h400000 >> 12);
      if (w) shadow[a[7:0]] = d;
      else chk(rdata == shadow[a[7:0]], "R4 random read data", rdata, shadow[a[7:0]]);
    end

    chk(viol == 0, "R1 R2 control word protocol", viol, 0);
    summary();
    $finish;
  end
endmodule